// File: doc/BRIEF.md
# Dual-Clock FIFO Controller

This block is the control logic for a first-in first-out buffer built on an external simple dual-port RAM. Producers push words on a write clock and consumers pull them on an independent read clock. The controller generates both RAM addresses itself, drives the RAM's write and read strobes, and returns the RAM's read word to the consumer as data and parity. Each pointer crosses to the other clock domain as Gray code through a two-flop synchroniser. Each side computes its own occupancy flags from its local pointer and the synchronised remote pointer.

Status comes in two groups. The write side has full, almost-full, a write-error strobe and a 12-bit write count. The read side has empty, almost-empty, a read-error strobe and a 12-bit read count. The almost thresholds are 12-bit configuration inputs and are expected to stay static. A build-time parameter selects the read behaviour. In standard mode, data appears one read clock after a read request. In fall-through mode, the head word is prefetched into view, and a read request consumes it.

The edges are plain enable strobes, not valid/ready pairs. The producer must watch `full` and the consumer must watch `empty`. A request made against the wrong flag is dropped and reported by a one-cycle error strobe, which is the back-pressure contract. One reset input clears both domains asynchronously.

Top module: `xclk_fifo_ctrl`

## Requirements
- R1: While and after reset, `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `wr_err`=0, `rd_err`=0 and both counts are 0.
- R2: Every accepted word leaves on `{doutp,dout}` exactly once, in write order, including when the addresses wrap past the RAM depth.
- R3: `full` is 1 when the RAM holds 2^AW words. A write while `full` is dropped: `wr_count` keeps its value and `wr_err` is 1 for exactly the next write-clock cycle.
- R4: A read while `empty` is dropped: `rd_count` keeps its value and `rd_err` is 1 for exactly the next read-clock cycle.
- R5: In standard mode (FWFT=0), a read accepted at a read-clock edge puts the head word on `dout`/`doutp` after that same edge.
- R6: In fall-through mode (FWFT=1), the head word appears on `dout` with `empty`=0 without any read request. A read request at an edge consumes the shown word, and the next word, if one is stored, is shown after that edge.
- R7: `almost_full` is 1 exactly when the write-side RAM occupancy plus `af_offset` is at least 2^AW.
- R8: `almost_empty` is 1 exactly when the number of words the consumer can still read is below `ae_offset`, for the same `ae_offset` in both modes. Internally the threshold is held as `ae_offset`-1 in standard mode and `ae_offset`-2 in fall-through mode.
- R9: `wr_count` counts accepted writes and `rd_count` counts RAM reads issued (in fall-through mode this includes the prefetch). Both are modulo 2^(AW+1), zero-extended to 12 bits, and step by at most 1 per cycle.
- R10: The Gray-coded pointer sent across each clock boundary changes in at most one bit per source-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous reset for both clock domains, active high |
| ae_offset | input | 12 | Almost-empty threshold in words (static) |
| af_offset | input | 12 | Almost-full threshold in free words (static) |
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| din | input | DATA_W | Write data |
| dinp | input | PAR_W | Write parity |
| full | output | 1 | RAM holds 2^AW words |
| almost_full | output | 1 | Occupancy within `af_offset` of full |
| wr_err | output | 1 | One-cycle strobe: previous write was dropped |
| wr_count | output | 12 | Accepted write count |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| dout | output | DATA_W | Read data |
| doutp | output | PAR_W | Read parity |
| empty | output | 1 | Nothing to read |
| almost_empty | output | 1 | Readable words below `ae_offset` |
| rd_err | output | 1 | One-cycle strobe: previous read was dropped |
| rd_count | output | 12 | RAM read count |
| ram_we | output | 1 | RAM write strobe (write clock) |
| ram_waddr | output | AW | RAM write address |
| ram_wdata | output | DATA_W+PAR_W | RAM write word, parity in the upper bits |
| ram_re | output | 1 | RAM read strobe (read clock) |
| ram_raddr | output | AW | RAM read address |
| ram_rdata | input | DATA_W+PAR_W | RAM registered read word, updated only when `ram_re` is 1 |

## Verification
The bench runs one standard instance and one fall-through instance side by side from the same stimulus. It goes after the points where the two modes diverge. A fall-through design that failed to prefetch would leave `empty` high with data stored. One whose threshold adjustment did not cancel would raise `almost_empty` one word early or late compared with the standard instance. The bench fills past capacity and reads past empty. A controller that let a dropped request move a pointer would show a count that advanced, a missing error pulse, or a duplicated or skipped word in the scoreboard. The run wraps the addresses, so a pointer or Gray conversion that mishandled the wrap would return words out of order.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

  localparam int CNT_W = 12;

  function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xclk_fifo_sync2.sv
module xclk_fifo_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xclk_fifo_wr_side.sv
module xclk_fifo_wr_side
  import xclk_fifo_pkg::*;
#(
  parameter int AW    = 4,
  parameter int WORDW = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WORDW-1:0] wdata,
  input  logic [AW:0]      rgray_sync,
  input  logic [CNT_W-1:0] af_off,
  output logic             full,
  output logic             almost_full,
  output logic             wr_err,
  output logic [CNT_W-1:0] wcount,
  output logic [AW:0]      wgray,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic [WORDW-1:0] ram_wdata
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0]  DEPTH_P = PW'(1 << AW);
  localparam logic [CNT_W:0] DEPTH_X = (CNT_W+1)'(1 << AW);

  logic [PW-1:0] wptr, wptr_nxt, rptr_b, level;
  logic          accept;

  assign rptr_b   = PW'(gray2bin(CNT_W'(rgray_sync)));
  assign level    = wptr - rptr_b;
  assign full     = (level == DEPTH_P);
  assign almost_full = ((CNT_W+1)'(level) + {1'b0, af_off}) >= DEPTH_X;
  assign accept   = wr_en && !full;
  assign wptr_nxt = wptr + PW'(accept);

  assign ram_we    = accept;
  assign ram_waddr = wptr[AW-1:0];
  assign ram_wdata = wdata;
  assign wcount    = CNT_W'(wptr);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wptr   <= '0;
      wgray  <= '0;
      wr_err <= 1'b0;
    end else begin
      wptr   <= wptr_nxt;
      wgray  <= PW'(bin2gray(CNT_W'(wptr_nxt)));
      wr_err <= wr_en && full;
    end
  end

  // R3: a write against full leaves the pointer where it was
  p_wr_hold_full_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> (wptr == $past(wptr)));

  // R9: the write pointer advances by at most one per cycle
  p_wptr_step_r9: assert property (@(posedge clk) disable iff (rst)
    (wptr == $past(wptr)) || (wptr == $past(wptr) + PW'(1)));

  // R10: the exported Gray pointer flips at most one bit per cycle
  p_wgray_step_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray)));
endmodule

// File: rtl/xclk_fifo_rd_side.sv
module xclk_fifo_rd_side
  import xclk_fifo_pkg::*;
#(
  parameter int AW   = 4,
  parameter bit FWFT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [AW:0]      wgray_sync,
  input  logic [CNT_W-1:0] ae_off,
  output logic             empty,
  output logic             almost_empty,
  output logic             rd_err,
  output logic [CNT_W-1:0] rcount,
  output logic [AW:0]      rgray,
  output logic             ram_re,
  output logic [AW-1:0]    ram_raddr
);
  localparam int PW  = AW + 1;
  localparam int ADJ = FWFT ? 2 : 1;

  logic [PW-1:0]    rptr, rptr_nxt, wptr_b, occ, level;
  logic [CNT_W-1:0] ae_store, ae_thr;
  logic             fetch, rd_miss;

  assign wptr_b   = PW'(gray2bin(CNT_W'(wgray_sync)));
  assign occ      = wptr_b - rptr;
  assign rptr_nxt = rptr + PW'(fetch);

  generate
    if (FWFT) begin : g_fwft
      logic shown;

      assign fetch   = (occ != '0) && (!shown || rd_en);
      assign empty   = !shown;
      assign rd_miss = rd_en && !shown;
      assign level   = occ + PW'(shown);

      always_ff @(posedge clk or posedge rst) begin
        if (rst) shown <= 1'b0;
        else     shown <= fetch || (shown && !rd_en);
      end

      // R6: a shown word stays shown until a read request takes it
      p_fwft_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (shown && !rd_en) |=> shown);
    end else begin : g_std
      assign fetch   = rd_en && (occ != '0);
      assign empty   = (occ == '0);
      assign rd_miss = rd_en && empty;
      assign level   = occ;

      // R4: a read against empty leaves the pointer where it was
      p_rd_hold_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> (rptr == $past(rptr)));
    end
  endgenerate

  // threshold held reduced by the mode's adjustment and restored at compare
  assign ae_thr       = ae_store + CNT_W'(ADJ);
  assign almost_empty = CNT_W'(level) < ae_thr;

  assign ram_re    = fetch;
  assign ram_raddr = rptr[AW-1:0];
  assign rcount    = CNT_W'(rptr);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rptr     <= '0;
      rgray    <= '0;
      rd_err   <= 1'b0;
      ae_store <= '0;
    end else begin
      rptr     <= rptr_nxt;
      rgray    <= PW'(bin2gray(CNT_W'(rptr_nxt)));
      rd_err   <= rd_miss;
      ae_store <= ae_off - CNT_W'(ADJ);
    end
  end

  // R9: the read pointer advances by at most one per cycle
  p_rptr_step_r9: assert property (@(posedge clk) disable iff (rst)
    (rptr == $past(rptr)) || (rptr == $past(rptr) + PW'(1)));

  // R10: the exported Gray pointer flips at most one bit per cycle
  p_rgray_step_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rgray ^ $past(rgray)));
endmodule

// File: rtl/xclk_fifo_ctrl.sv
module xclk_fifo_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 4,
  parameter int AW     = 4,
  parameter bit FWFT   = 1'b0
) (
  input  logic                    rst,
  input  logic [11:0]             ae_offset,
  input  logic [11:0]             af_offset,
  input  logic                    wclk,
  input  logic                    wr_en,
  input  logic [DATA_W-1:0]       din,
  input  logic [PAR_W-1:0]        dinp,
  output logic                    full,
  output logic                    almost_full,
  output logic                    wr_err,
  output logic [11:0]             wr_count,
  input  logic                    rclk,
  input  logic                    rd_en,
  output logic [DATA_W-1:0]       dout,
  output logic [PAR_W-1:0]        doutp,
  output logic                    empty,
  output logic                    almost_empty,
  output logic                    rd_err,
  output logic [11:0]             rd_count,
  output logic                    ram_we,
  output logic [AW-1:0]           ram_waddr,
  output logic [DATA_W+PAR_W-1:0] ram_wdata,
  output logic                    ram_re,
  output logic [AW-1:0]           ram_raddr,
  input  logic [DATA_W+PAR_W-1:0] ram_rdata
);
  localparam int WORDW = DATA_W + PAR_W;
  localparam int PW    = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_at_rd, rgray_at_wr;

  xclk_fifo_wr_side #(.AW(AW), .WORDW(WORDW)) u_wr (
    .clk         (wclk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wdata       ({dinp, din}),
    .rgray_sync  (rgray_at_wr),
    .af_off      (af_offset),
    .full        (full),
    .almost_full (almost_full),
    .wr_err      (wr_err),
    .wcount      (wr_count),
    .wgray       (wgray),
    .ram_we      (ram_we),
    .ram_waddr   (ram_waddr),
    .ram_wdata   (ram_wdata)
  );

  xclk_fifo_sync2 #(.W(PW)) u_w2r (
    .clk (rclk), .rst (rst), .d (wgray), .q (wgray_at_rd)
  );

  xclk_fifo_sync2 #(.W(PW)) u_r2w (
    .clk (wclk), .rst (rst), .d (rgray), .q (rgray_at_wr)
  );

  xclk_fifo_rd_side #(.AW(AW), .FWFT(FWFT)) u_rd (
    .clk          (rclk),
    .rst          (rst),
    .rd_en        (rd_en),
    .wgray_sync   (wgray_at_rd),
    .ae_off       (ae_offset),
    .empty        (empty),
    .almost_empty (almost_empty),
    .rd_err       (rd_err),
    .rcount       (rd_count),
    .rgray        (rgray),
    .ram_re       (ram_re),
    .ram_raddr    (ram_raddr)
  );

  assign dout  = ram_rdata[DATA_W-1:0];
  assign doutp = ram_rdata[WORDW-1:DATA_W];
endmodule

// File: tb/xclk_fifo_ctrl_tb.sv
module xclk_fifo_tb_ram #(
  parameter int AW = 4,
  parameter int W  = 36
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [1<<AW];
  always @(posedge wclk) if (we) mem[waddr] <= wdata;
  always @(posedge rclk) if (re) q <= mem[raddr];
endmodule

module xclk_fifo_ctrl_tb;
  localparam int DW = 32, PWD = 4, AW = 4, RW = 36;

  logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0]  din = '0;
  logic [PWD-1:0] dinp = '0;
  logic [11:0] ae_off = 12'd4, af_off = 12'd3;

  logic s_full, s_af, s_werr, s_empty, s_ae, s_rerr, s_we, s_re;
  logic f_full, f_af, f_werr, f_empty, f_ae, f_rerr, f_we, f_re;
  logic [11:0] s_wc, s_rc, f_wc, f_rc;
  logic [DW-1:0] s_dout, f_dout;
  logic [PWD-1:0] s_doutp, f_doutp;
  logic [AW-1:0] s_wa, s_ra, f_wa, f_ra;
  logic [RW-1:0] s_wd, s_rd, f_wd, f_rd;

  xclk_fifo_ctrl #(.DATA_W(DW), .PAR_W(PWD), .AW(AW), .FWFT(1'b0)) u_dut (
    .rst(rst), .ae_offset(ae_off), .af_offset(af_off),
    .wclk(wclk), .wr_en(wr_en), .din(din), .dinp(dinp),
    .full(s_full), .almost_full(s_af), .wr_err(s_werr), .wr_count(s_wc),
    .rclk(rclk), .rd_en(rd_en), .dout(s_dout), .doutp(s_doutp),
    .empty(s_empty), .almost_empty(s_ae), .rd_err(s_rerr), .rd_count(s_rc),
    .ram_we(s_we), .ram_waddr(s_wa), .ram_wdata(s_wd),
    .ram_re(s_re), .ram_raddr(s_ra), .ram_rdata(s_rd));

  xclk_fifo_ctrl #(.DATA_W(DW), .PAR_W(PWD), .AW(AW), .FWFT(1'b1)) u_dut_fwft (
    .rst(rst), .ae_offset(ae_off), .af_offset(af_off),
    .wclk(wclk), .wr_en(wr_en), .din(din), .dinp(dinp),
    .full(f_full), .almost_full(f_af), .wr_err(f_werr), .wr_count(f_wc),
    .rclk(rclk), .rd_en(rd_en), .dout(f_dout), .doutp(f_doutp),
    .empty(f_empty), .almost_empty(f_ae), .rd_err(f_rerr), .rd_count(f_rc),
    .ram_we(f_we), .ram_waddr(f_wa), .ram_wdata(f_wd),
    .ram_re(f_re), .ram_raddr(f_ra), .ram_rdata(f_rd));

  xclk_fifo_tb_ram #(.AW(AW), .W(RW)) u_ram_s (
    .wclk(wclk), .we(s_we), .waddr(s_wa), .wdata(s_wd),
    .rclk(rclk), .re(s_re), .raddr(s_ra), .q(s_rd));

  xclk_fifo_tb_ram #(.AW(AW), .W(RW)) u_ram_f (
    .wclk(wclk), .we(f_we), .waddr(f_wa), .wdata(f_wd),
    .rclk(rclk), .re(f_re), .raddr(f_ra), .q(f_rd));

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  bit s_pend = 1'b0;
  logic [RW-1:0] q_s[$];
  logic [RW-1:0] q_f[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] word(input int i);
    return {4'(i) ^ 4'h9, 32'hC0DE0000 | 32'(i * 7)};
  endfunction

  task automatic wr(input logic [RW-1:0] w);
    wr_en = 1'b1;
    {dinp, din} = w;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rd();
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  // scoreboard feed: each accepted write is queued for each instance
  always @(posedge wclk) begin
    if (!rst && wr_en && !s_full) q_s.push_back({dinp, din});
    if (!rst && wr_en && !f_full) q_f.push_back({dinp, din});
  end

  // monitors: fall-through compares the shown word at the consuming edge,
  // standard compares one half-cycle after the accepting edge
  always @(posedge rclk) begin
    if (!rst && rd_en && !s_empty) s_pend = 1'b1;
    if (!rst && rd_en && !f_empty) begin
      if (q_f.size() == 0) chk("R2 fwft unexpected word", 64'({f_doutp, f_dout}), 64'hDEAD);
      else chk("R6/R2 fwft read data", 64'({f_doutp, f_dout}), 64'(q_f.pop_front()));
    end
  end

  always @(negedge rclk) begin
    if (s_pend) begin
      s_pend = 1'b0;
      if (q_s.size() == 0) chk("R2 std unexpected word", 64'({s_doutp, s_dout}), 64'hDEAD);
      else chk("R5/R2 std read data", 64'({s_doutp, s_dout}), 64'(q_s.pop_front()));
    end
  end

  initial begin
    repeat (5) @(posedge wclk);
    repeat (3) @(posedge rclk);
    @(negedge wclk);
    rst = 1'b0;
    repeat (3) @(negedge rclk);

    // R1 reset state
    chk("R1 std empty", 64'(s_empty), 64'd1);
    chk("R1 fwft empty", 64'(f_empty), 64'd1);
    chk("R1 std full", 64'(s_full), 64'd0);
    chk("R1 std almost_empty", 64'(s_ae), 64'd1);
    chk("R1 fwft almost_empty", 64'(f_ae), 64'd1);
    chk("R1 std almost_full", 64'(s_af), 64'd0);
    chk("R1 counts", 64'({s_wc, s_rc, f_wc, f_rc}), 64'd0);
    chk("R1 error strobes", 64'({s_werr, s_rerr, f_werr, f_rerr}), 64'd0);

    // R4 read while empty
    rd();
    chk("R4 std rd_err pulse", 64'(s_rerr), 64'd1);
    chk("R4 fwft rd_err pulse", 64'(f_rerr), 64'd1);
    chk("R4 std rd_count unchanged", 64'(s_rc), 64'd0);
    @(negedge rclk);
    chk("R4 rd_err one cycle", 64'({s_rerr, f_rerr}), 64'd0);

    // four words, then compare the modes after the crossing settles
    @(negedge wclk);
    for (int i = 0; i < 4; i++) wr(word(i));
    chk("R9 wr_count after 4", 64'(s_wc), 64'd4);
    repeat (8) @(negedge rclk);
    chk("R6 fwft shows head unrequested", 64'(f_empty), 64'd0);
    chk("R6 fwft head word", 64'({f_doutp, f_dout}), 64'(word(0)));
    chk("R5 std not empty", 64'(s_empty), 64'd0);
    chk("R9 fwft rd_count counts prefetch", 64'(f_rc), 64'd1);
    chk("R9 std rd_count before read", 64'(s_rc), 64'd0);
    chk("R8 std almost_empty at 4 readable", 64'(s_ae), 64'd0);
    chk("R8 fwft almost_empty at 4 readable", 64'(f_ae), 64'd0);

    rd();
    chk("R8 std almost_empty at 3 readable", 64'(s_ae), 64'd1);
    chk("R8 fwft almost_empty at 3 readable", 64'(f_ae), 64'd1);
    rd(); rd(); rd();
    repeat (2) @(negedge rclk);
    chk("R2 std drained empty", 64'(s_empty), 64'd1);
    chk("R6 fwft drained empty", 64'(f_empty), 64'd1);

    // fill past capacity; fall-through holds one extra in the output stage
    @(negedge wclk);
    wr(word(10));
    repeat (16) @(negedge wclk);
    for (int i = 1; i <= 17; i++) begin
      wr(word(10 + i));
      if (i + 1 == 12) chk("R7 std almost_full at 12", 64'(s_af), 64'd0);
      if (i + 1 == 13) chk("R7 std almost_full at 13", 64'(s_af), 64'd1);
      if (i + 1 == 16) chk("R3 std full at depth", 64'(s_full), 64'd1);
      if (i + 1 == 17) begin
        chk("R3 std wr_err on overflow", 64'(s_werr), 64'd1);
        chk("R3 std wr_count held", 64'(s_wc), 64'd20);
        chk("R3 fwft accepted 17th", 64'(f_werr), 64'd0);
        chk("R3 fwft full", 64'(f_full), 64'd1);
      end
    end
    wr(word(99));
    chk("R3 fwft wr_err on overflow", 64'(f_werr), 64'd1);
    chk("R3 fwft wr_count held", 64'(f_wc), 64'd21);
    @(negedge wclk);
    chk("R3 wr_err one cycle", 64'({s_werr, f_werr}), 64'd0);

    // drain through the address wrap
    repeat (6) @(negedge rclk);
    for (int i = 0; i < 17; i++) rd();
    repeat (4) @(negedge rclk);
    chk("R2 std scoreboard drained", 64'(q_s.size()), 64'd0);
    chk("R2 fwft scoreboard drained", 64'(q_f.size()), 64'd0);
    chk("R9 std rd_count final", 64'(s_rc), 64'd20);
    chk("R9 fwft rd_count final", 64'(f_rc), 64'd21);
    chk("R2 both empty at end", 64'({s_empty, f_empty}), 64'd3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge wclk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule